// File: doc/BRIEF.md
# Load/Store Queue with Store-to-Load Forwarding

This block tracks the memory operations of an out-of-order core in program order. Each load or store takes an entry when it is dispatched, and the entry number returned at that moment is its tag. The operation's word address, and for a store its write data, arrive later through a resolve port that is indexed by tag. Operations may resolve in any order.

A load with a resolved address becomes eligible once every store older than it has a resolved address. If none of those stores targets the same word, the load goes to the data cache as a read. If one or more of them match, the data comes from the youngest matching store and is returned on a separate result port without a cache access. Stores never write the cache speculatively. A store's write is issued in the cycle it retires from the head of the queue.

Entries leave the queue in program order through a retire handshake. A flush input discards everything in the queue. The queue depth is half of the instruction window size.

Top module: `lsq_top`

## Requirements
- R1: A load is neither sent to the cache nor forwarded while any older store in the queue has an unresolved address.
- R2: A resolved load whose older stores are all resolved, none at its word address, produces a cache read (`mem_valid`=1, `mem_write`=0) carrying its address and its tag on `mem_tag`.
- R3: A resolved load with at least one resolved older store at the same word address returns that store's data on `fwd_valid`/`fwd_tag`/`fwd_data` and makes no cache access.
- R4: When several older stores match, the data comes from the youngest of them. Stores younger than the load are never used.
- R5: A cache write (`mem_write`=1) is issued only in the cycle a store retires. It carries that store's address and data.
- R6: Retirement is in program order. `retire_ready` is 1 only when the oldest entry is a store with a resolved address, or a load that has already been sent to the cache or forwarded. A retire request is ignored when `retire_ready` is 0.
- R7: Each cycle carries at most one load action (cache read or forward). A retiring store takes the cache port, and any eligible load waits for the following cycle.
- R8: The queue holds WINDOW/2 entries. `alloc_ready` is 0 exactly when all entries are occupied, and an allocation request is then ignored.
- R9: A flush empties the queue. Flushed stores never reach the cache, and operations allocated after the flush see only retired stores.
- R10: After reset the queue is empty: `alloc_ready`=1, `retire_ready`=0, `mem_valid`=0 and `fwd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all entries |
| alloc_valid | input | 1 | Allocate an entry for the next operation in program order |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_ready | output | 1 | An entry is free |
| alloc_tag | output | IW | Tag given to the operation allocated this cycle |
| res_valid | input | 1 | Resolve an entry's address (and its data, for a store) |
| res_tag | input | IW | Entry being resolved |
| res_addr | input | AW | Word address |
| res_data | input | DW | Store data (ignored for loads) |
| retire_valid | input | 1 | Request retirement of the oldest entry |
| retire_ready | output | 1 | The oldest entry may retire |
| mem_valid | output | 1 | Cache request this cycle |
| mem_write | output | 1 | 1 = store write, 0 = load read |
| mem_addr | output | AW | Request word address |
| mem_wdata | output | DW | Write data |
| mem_tag | output | IW | Entry that issued the request |
| fwd_valid | output | 1 | Load result taken from the queue |
| fwd_tag | output | IW | Load receiving the forwarded data |
| fwd_data | output | DW | Forwarded data |

## Verification
The bench replays every operation against a sequential program-order model and compares each load value with it, whether the value came from the cache or was forwarded. A design that issues a load early past an unresolved store, or that forwards from the oldest rather than the youngest matching store, returns stale data and fails that comparison. Targeted cases cover the following:
- a load resolved before its older store, which must stay silent;
- a store younger than the load at the same address, which must be skipped;
- a store retiring in the same cycle a load becomes eligible, where the load must yield;
- a full queue, where the extra allocation must be dropped;
- a flush with a resolved store inside it, whose data must never surface.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  // Which user owns the cache port in a given cycle.
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_STORE = 2'd1,
    PORT_READ  = 2'd2,
    PORT_FWD   = 2'd3
  } lsq_port_e;
endpackage

// File: rtl/lsq_scan.sv
// Per-entry hazard scan: decides if the load in entry SELF may act, and
// finds the youngest older store at the same word address.
module lsq_scan #(
  parameter int DEPTH = 32,
  parameter int IW    = 5,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SELF  = 0
) (
  input  logic [DEPTH-1:0] vld_i,
  input  logic [DEPTH-1:0] st_i,
  input  logic [DEPTH-1:0] known_i,
  input  logic [DEPTH-1:0] done_i,
  input  logic [AW-1:0]    addr_i [DEPTH],
  input  logic [DW-1:0]    data_i [DEPTH],
  input  logic [IW-1:0]    head_i,
  output logic             ready_o,
  output logic             hit_o,
  output logic [DW-1:0]    hit_data_o
);
  // DEPTH is a power of two, so age is a plain modular subtraction.
  logic [IW-1:0] self_age;
  logic [IW-1:0] best_age;
  logic [IW-1:0] j_age;

  assign self_age = IW'(SELF) - head_i;

  always_comb begin
    ready_o    = vld_i[SELF] && !st_i[SELF] && known_i[SELF] && !done_i[SELF];
    hit_o      = 1'b0;
    hit_data_o = '0;
    best_age   = '0;
    j_age      = '0;
    for (int j = 0; j < DEPTH; j++) begin
      j_age = IW'(j) - head_i;
      if (j != SELF && vld_i[j] && st_i[j] && (j_age < self_age)) begin
        if (!known_i[j]) begin
          ready_o = 1'b0;
        end else if (addr_i[j] == addr_i[SELF] && (!hit_o || j_age > best_age)) begin
          hit_o      = 1'b1;
          best_age   = j_age;
          hit_data_o = data_i[j];
        end
      end
    end
  end
endmodule

// File: rtl/lsq_pick.sv
// Oldest-first selection among eligible loads, scanning from the head.
module lsq_pick #(
  parameter int DEPTH = 32,
  parameter int IW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] req_i,
  input  logic [IW-1:0]    head_i,
  output logic             any_o,
  output logic [IW-1:0]    sel_o
);
  logic [IW-1:0] idx;

  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    idx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_i + IW'(k);
      if (!any_o && req_i[idx]) begin
        any_o = 1'b1;
        sel_o = idx;
      end
    end
  end

  // R7: the selected entry really is an eligible load
  a_r7_pick_is_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req_i[sel_o]);
endmodule

// File: rtl/lsq_top.sv
module lsq_top #(
  parameter int WINDOW = 64,
  parameter int AW     = 32,
  parameter int DW     = 32,
  localparam int DEPTH = WINDOW / 2,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          alloc_valid,
  input  logic          alloc_store,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_tag,
  input  logic          res_valid,
  input  logic [IW-1:0] res_tag,
  input  logic [AW-1:0] res_addr,
  input  logic [DW-1:0] res_data,
  input  logic          retire_valid,
  output logic          retire_ready,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [IW-1:0] mem_tag,
  output logic          fwd_valid,
  output logic [IW-1:0] fwd_tag,
  output logic [DW-1:0] fwd_data
);
  import lsq_pkg::*;

  // Entry flags and pointers (reset); payload arrays (no reset).
  logic [DEPTH-1:0] vld_q, vld_d, st_q, st_d, known_q, known_d, done_q, done_d;
  logic [IW-1:0]    head_q, head_d, tail_q, tail_d;
  logic [IW:0]      cnt_q, cnt_d;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];

  logic             alloc_fire, ret_fire, st_ret, res_we, ld_any, ld_fire;
  logic [IW-1:0]    ld_sel;
  logic [DEPTH-1:0] ld_rdy, ld_hit;
  logic [DW-1:0]    ld_fdata [DEPTH];
  lsq_port_e        port_use;

  // Per-entry hazard scan
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_scan
    lsq_scan #(.DEPTH(DEPTH), .IW(IW), .AW(AW), .DW(DW), .SELF(gi)) u_scan (
      .vld_i      (vld_q),
      .st_i       (st_q),
      .known_i    (known_q),
      .done_i     (done_q),
      .addr_i     (addr_q),
      .data_i     (data_q),
      .head_i     (head_q),
      .ready_o    (ld_rdy[gi]),
      .hit_o      (ld_hit[gi]),
      .hit_data_o (ld_fdata[gi])
    );
  end

  lsq_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (ld_rdy),
    .head_i (head_q),
    .any_o  (ld_any),
    .sel_o  (ld_sel)
  );

  // Handshakes and port arbitration
  assign alloc_ready  = (cnt_q < (IW+1)'(DEPTH));
  assign alloc_tag    = tail_q;
  assign retire_ready = vld_q[head_q] && (st_q[head_q] ? known_q[head_q] : done_q[head_q]);
  assign alloc_fire   = alloc_valid && alloc_ready && !flush;
  assign ret_fire     = retire_valid && retire_ready && !flush;
  assign st_ret       = ret_fire && st_q[head_q];
  assign res_we       = res_valid && vld_q[res_tag] && !flush;
  assign ld_fire      = ld_any && !st_ret && !flush;

  always_comb begin
    if (st_ret)                 port_use = PORT_STORE;
    else if (!ld_fire)          port_use = PORT_IDLE;
    else if (ld_hit[ld_sel])    port_use = PORT_FWD;
    else                        port_use = PORT_READ;
  end

  assign mem_valid = (port_use == PORT_STORE) || (port_use == PORT_READ);
  assign mem_write = (port_use == PORT_STORE);
  assign mem_tag   = st_ret ? head_q : ld_sel;
  assign mem_addr  = addr_q[mem_tag];
  assign mem_wdata = st_ret ? data_q[head_q] : '0;
  assign fwd_valid = (port_use == PORT_FWD);
  assign fwd_tag   = ld_sel;
  assign fwd_data  = ld_fdata[ld_sel];

  // Next state
  always_comb begin
    vld_d   = vld_q;
    st_d    = st_q;
    known_d = known_q;
    done_d  = done_q;
    head_d  = head_q;
    tail_d  = tail_q;
    cnt_d   = cnt_q + (IW+1)'(alloc_fire) - (IW+1)'(ret_fire);
    if (alloc_fire) begin
      vld_d[tail_q]   = 1'b1;
      st_d[tail_q]    = alloc_store;
      known_d[tail_q] = 1'b0;
      done_d[tail_q]  = 1'b0;
      tail_d          = tail_q + 1'b1;
    end
    if (res_we)  known_d[res_tag] = 1'b1;
    if (ld_fire) done_d[ld_sel]   = 1'b1;
    if (ret_fire) begin
      vld_d[head_q] = 1'b0;
      head_d        = head_q + 1'b1;
    end
    if (flush) begin
      vld_d  = '0;
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      st_q    <= '0;
      known_q <= '0;
      done_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
    end else begin
      vld_q   <= vld_d;
      st_q    <= st_d;
      known_q <= known_d;
      done_q  <= done_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
      cnt_q   <= cnt_d;
    end
  end

  // Payload registers, written only on resolve
  always_ff @(posedge clk) begin
    if (res_we) begin
      addr_q[res_tag] <= res_addr;
      data_q[res_tag] <= res_data;
    end
  end

  // Assertions
  // R5: cache writes only accompany an accepted retire request
  a_r5_write_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (retire_valid && retire_ready));
  // R7: never a cache request and a forward in the same cycle
  a_r7_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, mem_valid}));
  // R8: occupancy never exceeds the depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (IW+1)'(DEPTH));
  // R9: a flush leaves nothing to retire
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (alloc_ready && !retire_ready && !mem_valid && !fwd_valid));
  // R6: an acted-on load is marked complete on the next cycle
  a_r6_load_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !flush) |=> done_q[$past(fwd_tag)]);
endmodule

// File: tb/tb_lsq_top.sv
`timescale 1ns/1ps
module tb_lsq_top;
  localparam int WINDOW = 64;
  localparam int DEPTH  = WINDOW / 2;
  localparam int IW     = $clog2(DEPTH);
  localparam int MAXOP  = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic flush, alloc_valid, alloc_store, res_valid, retire_valid;
  logic [IW-1:0] res_tag;
  logic [31:0] res_addr, res_data;
  logic alloc_ready, retire_ready, mem_valid, mem_write, fwd_valid;
  logic [IW-1:0] alloc_tag, mem_tag, fwd_tag;
  logic [31:0] mem_addr, mem_wdata, fwd_data;

  always #4 clk = ~clk;

  lsq_top #(.WINDOW(WINDOW), .AW(32), .DW(32)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_store(alloc_store),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_addr(res_addr), .res_data(res_data),
    .retire_valid(retire_valid), .retire_ready(retire_ready),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_tag(mem_tag),
    .fwd_valid(fwd_valid), .fwd_tag(fwd_tag), .fwd_data(fwd_data)
  );

  int checks = 0, fails = 0;
  int n_fwd = 0, n_rd = 0, n_wr = 0;
  bit cyc_fwd, cyc_rd, cyc_wr;
  logic [31:0] last_fwd_data, last_rd_addr;
  logic [IW-1:0] last_tag;

  // Program-order record of every operation
  bit          op_st [MAXOP];
  bit          op_known [MAXOP];
  bit          op_dead [MAXOP];
  logic [31:0] op_addr [MAXOP];
  logic [31:0] op_data [MAXOP];
  int          tag2seq [DEPTH];
  int          nops = 0, hd = 0;
  logic [31:0] mem_model [16];

  function automatic logic [31:0] init_word(logic [31:0] a);
    return 32'hA000_0000 + a;
  endfunction

  // Sequential reference value of load s
  function automatic logic [31:0] ref_val(int s);
    logic [31:0] v = init_word(op_addr[s]);
    for (int k = 0; k < s; k++)
      if (!op_dead[k] && op_st[k] && op_addr[k] == op_addr[s]) v = op_data[k];
    return v;
  endfunction

  function automatic bit older_unknown(int s);
    for (int k = hd; k < s; k++)
      if (op_st[k] && !op_known[k]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit older_match(int s);
    for (int k = hd; k < s; k++)
      if (op_st[k] && op_known[k] && op_addr[k] == op_addr[s]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Observe outputs before the edge and update the reference model
  task automatic observe();
    int s;
    cyc_fwd = 0; cyc_rd = 0; cyc_wr = 0;
    if (mem_valid && mem_write) begin
      cyc_wr = 1; n_wr++;
      chk(op_st[hd] && retire_valid && mem_addr == op_addr[hd] && mem_wdata == op_data[hd],
          "R5 store write", mem_wdata, op_data[hd]);
      mem_model[mem_addr[3:0]] = mem_wdata;
    end
    if (mem_valid && !mem_write) begin
      cyc_rd = 1; n_rd++; last_rd_addr = mem_addr; last_tag = mem_tag;
      s = tag2seq[mem_tag];
      chk(!older_unknown(s), "R1 read past unresolved store", 32'd1, 32'd0);
      chk(!older_match(s) && mem_addr == op_addr[s], "R2 read address", mem_addr, op_addr[s]);
      chk(mem_model[mem_addr[3:0]] == ref_val(s), "R2 read value",
          mem_model[mem_addr[3:0]], ref_val(s));
    end
    if (fwd_valid) begin
      cyc_fwd = 1; n_fwd++; last_fwd_data = fwd_data; last_tag = fwd_tag;
      s = tag2seq[fwd_tag];
      chk(!older_unknown(s), "R1 forward past unresolved store", 32'd1, 32'd0);
      chk(fwd_data == ref_val(s), "R3/R4 forwarded value", fwd_data, ref_val(s));
    end
    if (flush) begin
      for (int k = hd; k < nops; k++) op_dead[k] = 1'b1;
      hd = nops;
    end else begin
      if (res_valid) begin
        s = tag2seq[res_tag];
        op_known[s] = 1'b1; op_addr[s] = res_addr; op_data[s] = res_data;
      end
      if (retire_valid && retire_ready) hd++;
      if (alloc_valid && alloc_ready) begin
        op_st[nops] = alloc_store; op_known[nops] = 0; op_dead[nops] = 0;
        op_addr[nops] = '0; op_data[nops] = '0;
        tag2seq[alloc_tag] = nops; last_tag = alloc_tag;
        nops++;
      end
    end
  endtask

  // Called at a negative edge with inputs already driven
  task automatic cyc();
    #1 observe();
    @(negedge clk);
    flush = 0; alloc_valid = 0; alloc_store = 0; res_valid = 0; retire_valid = 0;
  endtask

  task automatic alloc(bit st, output logic [IW-1:0] tag);
    alloc_valid = 1; alloc_store = st;
    cyc();
    tag = last_tag;
  endtask

  task automatic resolve(logic [IW-1:0] tag, logic [31:0] a, logic [31:0] d);
    res_valid = 1; res_tag = tag; res_addr = a; res_data = d;
    cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && hd < nops; i++) begin
      retire_valid = 1;
      cyc();
    end
  endtask

  // Scenarios
  task automatic t_reset();
    #1;
    chk(alloc_ready == 1, "R10 alloc_ready", alloc_ready, 1);
    chk(retire_ready == 0, "R10 retire_ready", retire_ready, 0);
    chk(mem_valid == 0 && fwd_valid == 0, "R10 outputs idle", {mem_valid, fwd_valid}, 0);
  endtask

  task automatic t_blocked_then_forward();
    logic [IW-1:0] ts, tl;
    int f0, r0, w0;
    alloc(1, ts); alloc(0, tl);
    resolve(tl, 32'd3, 32'd0);
    f0 = n_fwd; r0 = n_rd;
    idle(4);
    chk(n_fwd == f0 && n_rd == r0, "R1 load held behind unresolved store", n_fwd + n_rd, f0 + r0);
    #1 chk(retire_ready == 0, "R6 unresolved store cannot retire", retire_ready, 0);
    resolve(ts, 32'd3, 32'h1111_0003);
    idle(2);
    chk(n_fwd == f0 + 1 && n_rd == r0, "R3 forwarded without cache read", n_fwd, f0 + 1);
    chk(last_fwd_data == 32'h1111_0003, "R3 forwarded data", last_fwd_data, 32'h1111_0003);
    w0 = n_wr;
    drain();
    chk(n_wr == w0 + 1, "R5 one write at retire", n_wr, w0 + 1);
  endtask

  task automatic t_youngest();
    logic [IW-1:0] a, b, l, c;
    alloc(1, a); alloc(1, b); alloc(0, l); alloc(1, c);
    resolve(c, 32'd7, 32'hC3C3_0007);
    resolve(l, 32'd7, 32'd0);
    resolve(a, 32'd7, 32'hA1A1_0007);
    resolve(b, 32'd7, 32'hB2B2_0007);
    idle(3);
    chk(last_fwd_data == 32'hB2B2_0007, "R4 youngest older store wins", last_fwd_data, 32'hB2B2_0007);
    drain();
  endtask

  task automatic t_no_match();
    logic [IW-1:0] s, l, l2;
    int r0;
    alloc(1, s); alloc(0, l);
    resolve(s, 32'd2, 32'h2222_0002);
    r0 = n_rd;
    resolve(l, 32'd9, 32'd0);
    idle(2);
    chk(n_rd == r0 + 1 && last_rd_addr == 32'd9, "R2 disjoint load reads cache", last_rd_addr, 32'd9);
    drain();
    alloc(0, l2);
    resolve(l2, 32'd2, 32'd0);
    idle(2);
    chk(n_rd == r0 + 2 && last_rd_addr == 32'd2, "R5 retired store visible in cache", last_rd_addr, 32'd2);
    drain();
  endtask

  task automatic t_priority();
    logic [IW-1:0] s, l;
    alloc(1, s);
    resolve(s, 32'd4, 32'h4444_0004);
    alloc(0, l);
    resolve(l, 32'd5, 32'd0);
    retire_valid = 1;
    cyc();
    chk(cyc_wr && !cyc_rd && !cyc_fwd, "R7 retiring store takes the port", {cyc_wr, cyc_rd, cyc_fwd}, 3'b100);
    cyc();
    chk(cyc_rd && last_rd_addr == 32'd5, "R7 load issues next cycle", last_rd_addr, 32'd5);
    drain();
  endtask

  task automatic t_full_and_flush();
    logic [IW-1:0] s, t;
    int w0, r0;
    alloc(1, s);
    resolve(s, 32'd1, 32'hDEAD_0001);
    for (int i = 1; i < DEPTH - 1; i++) alloc(0, t);
    #1 chk(alloc_ready == 1, "R8 one entry left", alloc_ready, 1);
    alloc(0, t);
    #1 chk(alloc_ready == 0, "R8 full at depth", alloc_ready, 0);
    alloc(0, t);
    chk(nops == hd + DEPTH, "R8 allocation ignored when full", nops - hd, DEPTH);
    w0 = n_wr;
    flush = 1;
    cyc();
    #1 chk(alloc_ready == 1 && retire_ready == 0, "R9 queue empty after flush",
           {alloc_ready, retire_ready}, 2'b10);
    r0 = n_rd;
    alloc(0, t);
    resolve(t, 32'd1, 32'd0);
    idle(2);
    chk(n_rd == r0 + 1 && n_wr == w0, "R9 flushed store never written", n_wr, w0);
    drain();
  endtask

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem_model[i] = init_word(32'(i));
    rst_n = 0; flush = 0; alloc_valid = 0; alloc_store = 0;
    res_valid = 0; res_tag = '0; res_addr = '0; res_data = '0; retire_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_blocked_then_forward();
    t_youngest();
    t_no_match();
    t_priority();
    t_full_and_flush();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule